// File: doc/BRIEF.md
# Address Tenure Termination Controller

This block ends the address phase of transactions on a split-transaction processor bus from the slave side. It watches for the active-low start-of-tenure strobe and waits a minimum number of address wait states. That minimum depends on the clock-ratio mode, and a programmable extra delay is added to it. It then drives the active-low acknowledge line with a fixed sequence: one clock asserted, one clock negated, and then the line is released.

The bus clock after the acknowledge clock is the retry window. The active-low retry input is sampled in every clock from the start strobe through that window. One clock after the window, the block raises exactly one of two pulses. `retried` means the whole transaction must be rerun, so no data phase may begin. `accepted` means the data phase may proceed. While a tenure is being handled, `pending` is high.

An accepted transaction stays outstanding until the data-phase logic pulses `data_done`. While it is outstanding, no further tenure is acknowledged, which keeps the pipeline depth at one. If an external responder claims the tenure, the block never drives acknowledge and abandons the tenure. There is no data stream at this block's edge, so every pin is a plain control or status signal and no valid/ready back-pressure applies.

Top module: `addr_term_ctrl`

## Requirements
- R1: After reset, `ack_oe` is 0, `pending` is 0, and `accepted` and `retried` are both 0.
- R2: With `slow_ratio`=0, `extra_wait`=0, an unclaimed tenure and no outstanding transaction, `ack_n`=0 with `ack_oe`=1 appears in the clock after the one in which `start_n` is low (clock 2 of the tenure, zero wait states).
- R3: With `slow_ratio`=1, acknowledge is never asserted before clock 3 of the tenure. With `extra_wait`=0, it is asserted exactly in clock 3.
- R4: Each unit of `extra_wait` delays the acknowledge clock by one more clock beyond the mode minimum.
- R5: Acknowledge is driven as one clock with `ack_oe`=1 and `ack_n`=0, then one clock with `ack_oe`=1 and `ack_n`=1, then `ack_oe`=0. At all other times `ack_oe` stays 0.
- R6: If `retry_n` is low in any clock from the start clock through the retry window (the clock after acknowledge), `retried` pulses for one clock, in the clock after the window. Retry in that later clock has no effect, and the tenure is accepted.
- R7: With no retry, `accepted` pulses for one clock in the clock after the retry window. `accepted` and `retried` are never high together.
- R8: After an accepted tenure, no later tenure is acknowledged until `data_done` is seen high. If `data_done` is high in clock d of a waiting tenure with wait count W, acknowledge comes in clock max(W,d)+1 counted from the start clock 0. This includes d=0, the same clock as `start_n`.
- R9: If `claim_n` is low in the start clock, or in any clock of the wait, the block never drives `ack_oe`, raises no outcome pulse, and drops `pending` in the next clock.
- R10: `pending` is 1 from the clock after the start through the retry window, and 0 in the clock of the outcome pulse.
- R11: A retried tenure leaves nothing outstanding, so the next tenure is acknowledged at its minimum wait without `data_done`.
- R12: A low `start_n` while `pending` is 1 is ignored and starts no second acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low start of address tenure |
| claim_n | input | 1 | Active-low external claim; responder owns termination |
| retry_n | input | 1 | Active-low address retry from snoopers |
| slow_ratio | input | 1 | 1 selects the slow clock-ratio mode (one wait state minimum) |
| extra_wait | input | EXTRA_W | Additional address wait states |
| data_done | input | 1 | Data phase of the outstanding transaction finished |
| ack_n | output | 1 | Active-low acknowledge value, valid while ack_oe is 1 |
| ack_oe | output | 1 | Output enable of the acknowledge pad; 0 means high impedance |
| pending | output | 1 | A tenure is being handled |
| accepted | output | 1 | One-clock pulse: tenure accepted |
| retried | output | 1 | One-clock pulse: tenure must be rerun |

## Verification
Two things can happen in the same clock: the depth-one hold is released, and a new tenure starts. The bench provokes this by driving `data_done` high in the very clock `start_n` is low, right after an accepted tenure. It expects acknowledge in clock 2 with no stall. A second case drives `data_done` late, in clock 6 of a waiting tenure, and the bench checks that acknowledge lands in clock 7. Retry arriving in the same clock that acknowledge is negated, which is the window clock, is also judged: the outcome must be `retried`, and a retry one clock later must leave the tenure accepted.

// File: rtl/atc_pkg.sv
`timescale 1ns/1ps
package atc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2,
    ST_WIN  = 2'd3
  } atc_state_e;
endpackage

// File: rtl/atc_wait_timer.sv
`timescale 1ns/1ps
module atc_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic             due
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign due = (cnt_q == '0);
endmodule

// File: rtl/atc_retry_track.sv
`timescale 1ns/1ps
module atc_retry_track (
  input  logic clk,
  input  logic rst_n,
  input  logic open,     // tenure start recognised this clock
  input  logic track,    // tenure in wait or acknowledge clock
  input  logic close,    // retry window clock
  input  logic retry_n,
  output logic accepted,
  output logic retried
);
  logic seen_q;
  logic final_retry;

  assign final_retry = seen_q | ~retry_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      accepted <= 1'b0;
      retried  <= 1'b0;
    end else begin
      if (open) begin
        seen_q <= ~retry_n;
      end else if (track) begin
        seen_q <= final_retry;
      end else begin
        seen_q <= 1'b0;
      end
      accepted <= close & ~final_retry;
      retried  <= close &  final_retry;
    end
  end
endmodule

// File: rtl/atc_depth_guard.sv
`timescale 1ns/1ps
module atc_depth_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clear,
  output logic outstanding,
  output logic slot_free
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
    end else if (set) begin
      outstanding <= 1'b1;
    end else if (clear) begin
      outstanding <= 1'b0;
    end
  end

  // A completion seen this clock frees the slot for an acknowledge decided now.
  assign slot_free = ~outstanding | clear;
endmodule

// File: rtl/atc_ack_drive.sv
`timescale 1ns/1ps
module atc_ack_drive #(
  parameter int PHASES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic ack_n,
  output logic ack_oe
);
  logic [PHASES-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q[0] <= 1'b0;
    else        ph_q[0] <= fire;
  end

  for (genvar g = 1; g < PHASES; g++) begin : g_phase
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q[g] <= 1'b0;
      else        ph_q[g] <= ph_q[g-1];
    end
  end

  assign ack_n  = ~ph_q[0];
  assign ack_oe = |ph_q;
endmodule

// File: rtl/addr_term_ctrl.sv
`timescale 1ns/1ps
module addr_term_ctrl #(
  parameter int EXTRA_W       = 3,
  parameter int SLOW_MIN_WAIT = 1,
  parameter int FAST_MIN_WAIT = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_n,
  input  logic               claim_n,
  input  logic               retry_n,
  input  logic               slow_ratio,
  input  logic [EXTRA_W-1:0] extra_wait,
  input  logic               data_done,
  output logic               ack_n,
  output logic               ack_oe,
  output logic               pending,
  output logic               accepted,
  output logic               retried
);
  import atc_pkg::*;

  localparam int MAX_MIN = (SLOW_MIN_WAIT > FAST_MIN_WAIT) ? SLOW_MIN_WAIT : FAST_MIN_WAIT;
  localparam int MAX_W   = MAX_MIN + (1 << EXTRA_W) - 1;
  localparam int CNT_W   = $clog2(MAX_W + 1) + 1;

  atc_state_e state_q, state_d;
  logic [CNT_W-1:0] wait_total, load_val;
  logic start_seen, claimed, due, slot_free, outstanding, fire;

  assign wait_total = (slow_ratio ? CNT_W'(SLOW_MIN_WAIT) : CNT_W'(FAST_MIN_WAIT))
                    + CNT_W'(extra_wait);
  assign load_val   = (wait_total == '0) ? '0 : wait_total - 1'b1;
  assign start_seen = (state_q == ST_IDLE) & ~start_n;
  assign claimed    = ~claim_n;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (!start_n) begin
        if (claimed)                                state_d = ST_IDLE;
        else if ((wait_total == '0) && slot_free)   state_d = ST_ACK;
        else                                        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (claimed)                state_d = ST_IDLE;
        else if (due && slot_free)  state_d = ST_ACK;
      end
      ST_ACK:  state_d = ST_WIN;
      ST_WIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign fire    = (state_d == ST_ACK) & (state_q != ST_ACK);
  assign pending = (state_q != ST_IDLE);

  atc_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_seen),
    .load_val (load_val),
    .step     (state_q == ST_WAIT),
    .due      (due)
  );

  atc_retry_track u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .open     (start_seen),
    .track    ((state_q == ST_WAIT) | (state_q == ST_ACK)),
    .close    (state_q == ST_WIN),
    .retry_n  (retry_n),
    .accepted (accepted),
    .retried  (retried)
  );

  atc_depth_guard u_depth (
    .clk         (clk),
    .rst_n       (rst_n),
    .set         ((state_q == ST_WIN) & retry_n & ~u_retry.seen_q),
    .clear       (data_done),
    .outstanding (outstanding),
    .slot_free   (slot_free)
  );

  atc_ack_drive #(.PHASES(2)) u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .ack_n  (ack_n),
    .ack_oe (ack_oe)
  );
endmodule

// File: rtl/atc_checker.sv
`timescale 1ns/1ps
module atc_checker #(
  parameter int EXTRA_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_n,
  input logic               claim_n,
  input logic               slow_ratio,
  input logic [EXTRA_W-1:0] extra_wait,
  input logic               data_done,
  input logic               ack_n,
  input logic               ack_oe,
  input logic               pending,
  input logic               accepted,
  input logic               retried,
  input logic               outstanding
);
  a_r2_zero_wait_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !start_n && claim_n && !slow_ratio && extra_wait == '0 && (!outstanding || data_done))
      |=> (ack_oe && !ack_n));

  a_r3_slow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !start_n && slow_ratio) |=> !(ack_oe && !ack_n));

  a_r5_negate_after_assert: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && !ack_n) |=> (ack_oe && ack_n));

  a_r5_release_after_negate: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && ack_n) |=> !ack_oe);

  a_r7_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(accepted && retried));

  a_r7_outcome_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted || retried) |-> $past(ack_oe && ack_n));

  a_r8_depth_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && !ack_n) |-> !outstanding);

  a_r9_claim_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !start_n && !claim_n) |=> (!ack_oe && !pending));

  a_r10_drive_in_tenure: assert property (@(posedge clk) disable iff (!rst_n)
    ack_oe |-> pending);
endmodule

bind addr_term_ctrl atc_checker #(.EXTRA_W(EXTRA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_n     (start_n),
  .claim_n     (claim_n),
  .slow_ratio  (slow_ratio),
  .extra_wait  (extra_wait),
  .data_done   (data_done),
  .ack_n       (ack_n),
  .ack_oe      (ack_oe),
  .pending     (pending),
  .accepted    (accepted),
  .retried     (retried),
  .outstanding (outstanding)
);

// File: tb/addr_term_ctrl_tb_top.sv
`timescale 1ns/1ps
module addr_term_ctrl_tb_top;
  localparam int EXTRA_W = 3;
  localparam int NC      = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1, claim_n = 1'b1, retry_n = 1'b1;
  logic slow_ratio = 1'b0, data_done = 1'b0;
  logic [EXTRA_W-1:0] extra_wait = '0;
  logic ack_n, ack_oe, pending, accepted, retried;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic o_ack [0:NC];
  logic o_neg [0:NC];
  logic o_oe  [0:NC];
  logic o_pend[0:NC];
  logic o_acc [0:NC];
  logic o_ret [0:NC];

  always #2 clk = ~clk;

  addr_term_ctrl #(.EXTRA_W(EXTRA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .claim_n(claim_n),
    .retry_n(retry_n), .slow_ratio(slow_ratio), .extra_wait(extra_wait),
    .data_done(data_done), .ack_n(ack_n), .ack_oe(ack_oe),
    .pending(pending), .accepted(accepted), .retried(retried)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic snap(input int k);
    o_ack[k]  = ack_oe & ~ack_n;
    o_neg[k]  = ack_oe & ack_n;
    o_oe[k]   = ack_oe;
    o_pend[k] = pending;
    o_acc[k]  = accepted;
    o_ret[k]  = retried;
  endtask

  // Clock 0 carries the start strobe; -1 means the event is not driven.
  task automatic run(input bit slow, input int extra, input int r_at,
                     input int cl_at, input int dd_at, input int ts2_at);
    slow_ratio = slow;
    extra_wait = EXTRA_W'(extra);
    for (int k = 0; k < NC; k++) begin
      start_n   = !((k == 0) || (k == ts2_at));
      retry_n   = !(k == r_at);
      claim_n   = !(k == cl_at);
      data_done = (k == dd_at);
      if (k == 0) snap(0);
      tick();
      snap(k + 1);
    end
    start_n = 1'b1; retry_n = 1'b1; claim_n = 1'b1; data_done = 1'b0;
  endtask

  function automatic int first_ack();
    for (int k = 0; k <= NC; k++) if (o_ack[k]) return k;
    return -1;
  endfunction

  function automatic int ack_count();
    int c = 0;
    for (int k = 0; k <= NC; k++) if (o_ack[k]) c++;
    return c;
  endfunction

  task automatic drain();
    data_done = 1'b1; tick(); data_done = 1'b0; tick(); tick();
  endtask

  // Checks the fixed termination sequence around acknowledge clock a.
  task automatic check_term(input string tag, input int a, input bit exp_retry);
    chk({tag, " R5 ack clock"}, first_ack(), a);
    chk({tag, " R5 negate clock"}, o_neg[a+1], 1);
    chk({tag, " R5 release"}, o_oe[a+2], 0);
    chk({tag, " R10 pending in window"}, o_pend[a+1], 1);
    chk({tag, " R10 pending drop"}, o_pend[a+2], 0);
    chk({tag, " R6 retried pulse"}, o_ret[a+2], exp_retry);
    chk({tag, " R7 accepted pulse"}, o_acc[a+2], !exp_retry);
    chk({tag, " R7 pulse one clock"}, o_acc[a+3] | o_ret[a+3], 0);
  endtask

  task automatic t_reset();
    chk("R1 ack_oe", ack_oe, 0);
    chk("R1 pending", pending, 0);
    chk("R1 accepted", accepted, 0);
    chk("R1 retried", retried, 0);
  endtask

  task automatic t_fast();
    drain();
    run(1'b0, 0, -1, -1, -1, -1);
    chk("R2 ack in clock 2", o_ack[1], 1);
    check_term("R2 fast", 1, 1'b0);
    chk("R10 pending from clock after start", o_pend[1], 1);
  endtask

  task automatic t_slow();
    drain();
    run(1'b1, 0, -1, -1, -1, -1);
    chk("R3 no ack in clock 2", o_ack[1], 0);
    check_term("R3 slow", 2, 1'b0);
  endtask

  task automatic t_extra();
    drain();
    run(1'b0, 3, -1, -1, -1, -1);
    check_term("R4 fast+3", 4, 1'b0);
    drain();
    run(1'b1, 2, -1, -1, -1, -1);
    check_term("R4 slow+2", 4, 1'b0);
    drain();
    run(1'b1, 7, -1, -1, -1, -1);
    check_term("R4 slow+7", 9, 1'b0);
  endtask

  task automatic t_retry();
    drain();
    run(1'b0, 0, 0, -1, -1, -1);
    check_term("R6 retry at start", 1, 1'b1);
    run(1'b1, 2, 2, -1, -1, -1);
    check_term("R6 retry mid wait", 4, 1'b1);
    run(1'b0, 0, 2, -1, -1, -1);
    check_term("R6 retry in window", 1, 1'b1);
    run(1'b0, 0, 3, -1, -1, -1);
    check_term("R6 retry after window", 1, 1'b0);
  endtask

  task automatic t_retry_frees();
    drain();
    run(1'b0, 0, 1, -1, -1, -1);
    check_term("R11 retried", 1, 1'b1);
    run(1'b0, 0, -1, -1, -1, -1);
    check_term("R11 next at minimum", 1, 1'b0);
  endtask

  task automatic t_depth();
    drain();
    run(1'b0, 0, -1, -1, -1, -1);
    check_term("R8 first", 1, 1'b0);
    run(1'b0, 0, -1, -1, 6, -1);
    chk("R8 held before done", o_ack[6], 0);
    chk("R8 pending while held", o_pend[5], 1);
    check_term("R8 late done", 7, 1'b0);
    run(1'b0, 0, -1, -1, 0, -1);
    check_term("R8 done with start", 1, 1'b0);
    run(1'b0, 0, -1, -1, -1, -1);
    chk("R8 no done no ack", ack_count(), 0);
    chk("R8 still pending", o_pend[NC], 1);
    data_done = 1'b1; tick(); data_done = 1'b0;
    chk("R8 ack after done", ack_oe & ~ack_n, 1);
    tick(); tick(); tick();
  endtask

  task automatic t_claim();
    drain();
    run(1'b0, 0, -1, 0, -1, -1);
    chk("R9 claim at start no drive", ack_count(), 0);
    chk("R9 claim at start pending", o_pend[1], 0);
    chk("R9 claim at start no accept", o_acc[3], 0);
    run(1'b1, 3, -1, 2, -1, -1);
    chk("R9 pending before claim", o_pend[2], 1);
    chk("R9 pending drop", o_pend[3], 0);
    chk("R9 claim mid no drive", ack_count(), 0);
    chk("R9 no outcome", o_acc[6] | o_ret[6], 0);
    run(1'b0, 0, -1, -1, -1, -1);
    check_term("R9 after claim", 1, 1'b0);
  endtask

  task automatic t_ignore();
    drain();
    run(1'b0, 0, 0, -1, -1, 2);
    check_term("R12 base", 1, 1'b1);
    chk("R12 single ack", ack_count(), 1);
    chk("R12 no new tenure", o_pend[4], 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    tick();
    t_fast();
    t_slow();
    t_extra();
    t_retry();
    t_retry_frees();
    t_depth();
    t_claim();
    t_ignore();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule